// File: doc/BRIEF.md
# Serial Register Target with Double-Buffered Commit

This block is the serial configuration port of a larger device. A host talks to it over a four-signal SPI link in mode 0: serial clock, active-low select, host data in, and target data out. Every transaction begins with a 16-bit instruction that gives the direction, the number of data bytes and a 12-bit byte address. The data bytes follow the instruction.

The block holds a run of general registers, one byte each. A host write lands only in a shadow copy. The values that drive the rest of the chip change only when the host writes a commit register, and then every register moves at once. A readback selector picks which copy a host read returns. A configuration byte chooses where read data goes: to the dedicated output, or back on the shared bidirectional line for 3-wire wiring. The same byte holds a soft-reset request. The serial signals are oversampled in the system clock domain, so the serial clock must run well below the system clock.

Top module: `spi_reg_target`

## Requirements
- R1: The instruction word is 16 bits, sent first. Bit 15 = 1 selects a read and 0 selects a write. Bits 14:13 hold a length code: code 0 moves one data byte, code 1 moves two, and codes 2 and 3 both move three. Bits 11:0 hold the starting byte address. Bit 12 is ignored.
- R2: Bits are sampled on the rising serial clock edge and read data changes after the falling edge. Each byte travels most significant bit first. The first data byte belongs to the instruction address, and the address drops by one after each byte, so a multi-byte register is named by its highest byte address.
- R3: A write to general register i (byte address GEN_BASE+i) changes only that register's shadow byte. The `active_o` bus is unchanged until a commit or a soft reset.
- R4: Writing a byte with bit 0 set to address 0x234 copies every shadow byte onto `active_o` (byte i at bits 8i+7:8i) in one step, one clock after the write. The commit bit clears itself, so reading 0x234 returns 0x00 afterwards.
- R5: Bit 0 of the byte at address 0x004 selects the read source for general registers: 1 returns the shadow copy and 0 returns the active copy.
- R6: Writing bit 5 of the configuration byte at address 0x000 raises `soft_rst_o` for exactly one clock. All registers then return to their defaults: configuration and readback selector 0x00, and both copies of general register i 0xA0+i. These are also the values after `rst_n`.
- R7: During the data phase of a read, only one output enable is asserted. `sdo_oe` is asserted when configuration bit 7 is 1, and `sdio_oe` is asserted when it is 0. Neither enable is asserted outside a read data phase.
- R8: Raising `cs_n` before a byte is complete drops the partial byte, whether it falls in the instruction or in the data. The next transaction is parsed from a fresh instruction.
- R9: Reading an address that holds no register returns 0x00. Writing such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial signals are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, mode 0 |
| cs_n | input | 1 | Active-low transaction select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data; drives the dedicated pin or the shared line |
| sdo_oe | output | 1 | Drive enable for the dedicated data-out pin (4-wire) |
| sdio_oe | output | 1 | Drive enable for the shared bidirectional line (3-wire) |
| active_o | output | NREG*8 | Committed register values, byte i at bits 8i+7:8i |
| soft_rst_o | output | 1 | One-clock pulse when a soft reset takes effect |

## Verification
The bench uses the default build: eight general registers at 0x010 to 0x017, with two synchronizer stages. With this build, a three-byte write that starts at the top register and runs downward is easy to reach. So are the unused neighbours just below and well above the general range, and a commit that moves all eight bytes at once. The serial clock runs at one sixteenth of the system clock. The synchronizer latency therefore lands well inside each half period, and read data is settled before the host samples it.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam logic [11:0] ADDR_CFG    = 12'h000;
  localparam logic [11:0] ADDR_RDSEL  = 12'h004;
  localparam logic [11:0] ADDR_COMMIT = 12'h234;

  localparam int CFG_SRST_BIT = 5;
  localparam int CFG_SDO_BIT  = 7;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  // Number of data bytes for a length code; codes 2 and 3 both mean three.
  function automatic logic [1:0] byte_total(input logic [1:0] code);
    return (code == 2'd3) ? 2'd3 : code + 2'd1;
  endfunction

  // Reset value of general register idx.
  function automatic logic [7:0] gen_default(input int unsigned idx);
    return 8'hA0 + 8'(idx);
  endfunction

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
  assign cs_idle   = cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_reg_parser.sv
module spi_reg_parser
  import spi_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_rise,
  input  logic        sclk_fall,
  input  logic        cs_idle,
  input  logic        mosi_s,
  input  logic        cfg_sdo,
  input  logic [7:0]  rd_data,
  output logic [11:0] rd_addr,
  output logic        wr_en,
  output logic [11:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        miso,
  output logic        sdo_oe,
  output logic        sdio_oe
);
  phase_e      phase;
  logic [3:0]  bit_cnt;
  logic [14:0] sh_q;
  logic        rd_q;
  logic [1:0]  left_q;
  logic [11:0] addr_q;
  logic [7:0]  tx_q;
  logic [15:0] instr_nxt;
  logic        byte_done;

  assign instr_nxt = {sh_q, mosi_s};
  assign byte_done = !cs_idle && sclk_rise && (phase == PH_DATA) && (bit_cnt == 4'd7);

  // Address whose byte is loaded for transmit at the next load point.
  assign rd_addr = (phase == PH_INSTR) ? instr_nxt[11:0] : addr_q - 12'd1;

  assign wr_en   = byte_done && !rd_q;
  assign wr_addr = addr_q;
  assign wr_data = instr_nxt[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
    end else if (cs_idle) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      sh_q <= instr_nxt[14:0];
      unique case (phase)
        PH_INSTR: begin
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd15) begin
            phase   <= PH_DATA;
            bit_cnt <= '0;
            rd_q    <= instr_nxt[15];
            left_q  <= byte_total(instr_nxt[14:13]);
            addr_q  <= instr_nxt[11:0];
            tx_q    <= rd_data;
          end
        end
        PH_DATA: begin
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            bit_cnt <= '0;
            addr_q  <= addr_q - 12'd1;
            left_q  <= left_q - 2'd1;
            tx_q    <= rd_data;
            if (left_q == 2'd1) phase <= PH_DONE;
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && phase == PH_DATA && bit_cnt != 4'd0) begin
      tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  logic rd_phase;
  assign rd_phase = (phase == PH_DATA) && rd_q && !cs_idle;
  assign miso     = tx_q[7];
  assign sdo_oe   = rd_phase && cfg_sdo;
  assign sdio_oe  = rd_phase && !cfg_sdo;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int          NREG     = 8,
  parameter logic [11:0] GEN_BASE = 12'h010,
  localparam int         BANK_W   = NREG * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [11:0]       rd_addr,
  output logic [7:0]        rd_data,
  output logic [BANK_W-1:0] active_o,
  output logic [BANK_W-1:0] shadow_o,
  output logic              cfg_sdo,
  output logic              soft_rst,
  output logic              commit
);
  logic [7:0] cfg_q;
  logic       rdsel_q;
  logic       commit_q;

  assign soft_rst = cfg_q[CFG_SRST_BIT];
  assign cfg_sdo  = cfg_q[CFG_SDO_BIT];
  assign commit   = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      rdsel_q  <= 1'b0;
      commit_q <= 1'b0;
    end else if (soft_rst) begin
      cfg_q    <= '0;
      rdsel_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (wr_en) begin
        if (wr_addr == ADDR_CFG)    cfg_q    <= wr_data;
        if (wr_addr == ADDR_RDSEL)  rdsel_q  <= wr_data[0];
        if (wr_addr == ADDR_COMMIT) commit_q <= wr_data[0];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] shd_r, act_r;
    logic       hit;
    assign hit = wr_en && (wr_addr == GEN_BASE + 12'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_r <= gen_default(g);
        act_r <= gen_default(g);
      end else if (soft_rst) begin
        shd_r <= gen_default(g);
        act_r <= gen_default(g);
      end else begin
        if (hit)      shd_r <= wr_data;
        if (commit_q) act_r <= shd_r;
      end
    end

    assign shadow_o[g*8 +: 8] = shd_r;
    assign active_o[g*8 +: 8] = act_r;
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_CFG)    rd_data = cfg_q;
    if (rd_addr == ADDR_RDSEL)  rd_data = {7'd0, rdsel_q};
    if (rd_addr == ADDR_COMMIT) rd_data = {7'd0, commit_q};
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == GEN_BASE + 12'(i))
        rd_data = rdsel_q ? shadow_o[i*8 +: 8] : active_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target #(
  parameter int          NREG        = 8,
  parameter logic [11:0] GEN_BASE    = 12'h010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            mosi,
  output logic            miso,
  output logic            sdo_oe,
  output logic            sdio_oe,
  output logic [NREG*8-1:0] active_o,
  output logic            soft_rst_o
);
  localparam int BANK_W = NREG * 8;

  logic              sclk_rise, sclk_fall, cs_idle, mosi_s;
  logic              wr_en, cfg_sdo, commit_pulse;
  logic [11:0]       wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;
  logic [BANK_W-1:0] shadow_bank;

  spi_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  spi_reg_parser u_parser (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .mosi_s(mosi_s), .cfg_sdo(cfg_sdo), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(miso), .sdo_oe(sdo_oe), .sdio_oe(sdio_oe)
  );

  spi_reg_bank #(.NREG(NREG), .GEN_BASE(GEN_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .active_o(active_o), .shadow_o(shadow_bank),
    .cfg_sdo(cfg_sdo), .soft_rst(soft_rst_o), .commit(commit_pulse)
  );
endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk
  import spi_reg_pkg::*;
#(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_idle,
  input logic              commit_pulse,
  input logic              soft_rst_o,
  input logic              sdo_oe,
  input logic              sdio_oe,
  input logic [NREG*8-1:0] active_o,
  input logic [NREG*8-1:0] shadow_bank
);
  function automatic logic [NREG*8-1:0] defaults();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = gen_default(i);
    return v;
  endfunction

  a_r3_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_pulse && !soft_rst_o) |=> $stable(active_o));

  a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && !soft_rst_o) |=> (active_o == $past(shadow_bank)));

  a_r4_commit_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  a_r6_reset_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  a_r6_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (active_o == defaults() && shadow_bank == defaults()));

  a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!sdo_oe && !sdio_oe));
endmodule

bind spi_reg_target spi_reg_target_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .commit_pulse(commit_pulse),
  .soft_rst_o(soft_rst_o), .sdo_oe(sdo_oe), .sdio_oe(sdio_oe),
  .active_o(active_o), .shadow_bank(shadow_bank)
);

// File: tb/test_spi_reg_target.sv
module test_spi_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREG       = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, sdo_oe, sdio_oe, soft_rst_o;
  logic [NREG*8-1:0] active_o;

  int n_checks = 0, n_bad = 0, sr_cnt = 0, mon_bits = 0;

  typedef struct {
    logic [7:0] data;
    bit         three_wire;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] m_act[NREG];
  logic [7:0] m_shd[NREG];

  spi_reg_target i_spi_reg_target (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .sdo_oe(sdo_oe), .sdio_oe(sdio_oe),
    .active_o(active_o), .soft_rst_o(soft_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] packed_act();
    logic [63:0] v = '0;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_act[i];
    return v;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: gathers read bytes as the design sends them and compares with the queue.
  initial begin
    logic [7:0] sh;
    bit mode3;
    forever begin
      @(posedge sclk);
      if (!cs_n && (sdo_oe || sdio_oe)) begin
        sh = {sh[6:0], miso};
        mode3 = sdio_oe;
        mon_bits++;
        if (mon_bits == 8) begin
          exp_t e;
          mon_bits = 0;
          n_checks++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R7 unexpected read byte actual=%h expected=none", sh);
          end else begin
            e = exp_q.pop_front();
            if (sh !== e.data || mode3 != e.three_wire) begin
              n_bad++;
              $display("FAIL %s actual=%h/3w=%0d expected=%h/3w=%0d",
                       e.tag, sh, mode3, e.data, e.three_wire);
            end
          end
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (soft_rst_o) sr_cnt++;
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b;
    clocks(HALF);
    sclk = 1'b1;
    clocks(HALF);
    sclk = 1'b0;
  endtask

  // Drives one transaction; ibits/dbits limit how many bits go out (for aborts).
  task automatic spi_xfer(input bit rd, input logic [1:0] code, input logic [11:0] addr,
                          input logic [23:0] wd, input int nbytes, input int ibits, input int dbits);
    logic [15:0] ins;
    ins = {rd, code, 1'b0, addr};
    mon_bits = 0;
    cs_n = 1'b0;
    clocks(HALF);
    for (int k = 0; k < ibits; k++) send_bit(ins[15-k]);
    for (int k = 0; k < dbits; k++) send_bit(wd[nbytes*8-1-k]);
    clocks(HALF);
    cs_n = 1'b1;
    clocks(12);
  endtask

  task automatic wr1(input logic [11:0] addr, input logic [7:0] d);
    spi_xfer(1'b0, 2'd0, addr, {16'd0, d}, 1, 16, 8);
  endtask

  task automatic rd_exp(input logic [11:0] addr, input logic [1:0] code, input int nbytes,
                        input logic [23:0] exp, input bit three_wire, input string tag);
    for (int b = nbytes - 1; b >= 0; b--) begin
      exp_t e;
      e.data = exp[b*8 +: 8];
      e.three_wire = three_wire;
      e.tag = tag;
      exp_q.push_back(e);
    end
    spi_xfer(1'b1, code, addr, 24'd0, nbytes, 16, nbytes * 8);
  endtask

  task automatic commit_model();
    for (int i = 0; i < NREG; i++) m_act[i] = m_shd[i];
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      m_act[i] = 8'hA0 + 8'(i);
      m_shd[i] = 8'hA0 + 8'(i);
    end
    clocks(5);
    rst_n = 1'b1;
    clocks(3);
    check(active_o, packed_act(), "R6 reset defaults");
    check({62'd0, sdo_oe, sdio_oe}, 64'd0, "R7 enables idle");

    wr1(12'h000, 8'h80);
    wr1(12'h010, 8'h3C); m_shd[0] = 8'h3C;
    check(active_o, packed_act(), "R3 shadow write holds active");
    rd_exp(12'h010, 2'd0, 1, 24'h0000A0, 1'b0, "R5 active readback");
    wr1(12'h004, 8'h01);
    rd_exp(12'h010, 2'd0, 1, 24'h00003C, 1'b0, "R5 shadow readback");
    wr1(12'h234, 8'h01); commit_model();
    check(active_o, packed_act(), "R4 commit");
    rd_exp(12'h234, 2'd0, 1, 24'h000000, 1'b0, "R4 commit bit self-clears");

    spi_xfer(1'b0, 2'd2, 12'h015, 24'h112233, 3, 16, 24);
    m_shd[5] = 8'h11; m_shd[4] = 8'h22; m_shd[3] = 8'h33;
    rd_exp(12'h015, 2'd2, 3, 24'h112233, 1'b0, "R2 descending three-byte read");
    check(active_o, packed_act(), "R3 multi-byte write holds active");
    wr1(12'h234, 8'h01); commit_model();
    check(active_o, packed_act(), "R2 descending write committed");

    spi_xfer(1'b0, 2'd3, 12'h017, 24'h445566, 3, 16, 24);
    m_shd[7] = 8'h44; m_shd[6] = 8'h55; m_shd[5] = 8'h66;
    wr1(12'h234, 8'h01); commit_model();
    check(active_o, packed_act(), "R1 code 3 moves three bytes");
    wr1(12'h004, 8'h00);
    rd_exp(12'h016, 2'd1, 2, 24'h005566, 1'b0, "R1 two-byte read");

    wr1(12'h050, 8'hFF);
    wr1(12'h00F, 8'hFF);
    rd_exp(12'h050, 2'd0, 1, 24'h000000, 1'b0, "R9 unused address reads zero");
    wr1(12'h234, 8'h01); commit_model();
    check(active_o, packed_act(), "R9 unused writes change nothing");

    wr1(12'h000, 8'h00);
    rd_exp(12'h016, 2'd0, 1, 24'h000055, 1'b1, "R7 three-wire read");

    spi_xfer(1'b0, 2'd0, 12'h011, 24'h0000EE, 1, 16, 5);
    wr1(12'h234, 8'h01); commit_model();
    check(active_o, packed_act(), "R8 partial data byte dropped");
    spi_xfer(1'b1, 2'd0, 12'h012, 24'd0, 1, 9, 0);
    rd_exp(12'h011, 2'd0, 1, 24'h0000A1, 1'b1, "R8 fresh parse after abort");
    rd_exp(12'h010, 2'd0, 1, 24'h00003C, 1'b1, "R8 second fresh parse");

    wr1(12'h004, 8'h01);
    wr1(12'h011, 8'h77);
    wr1(12'h000, 8'h20);
    for (int i = 0; i < NREG; i++) begin
      m_act[i] = 8'hA0 + 8'(i);
      m_shd[i] = 8'hA0 + 8'(i);
    end
    check(64'(sr_cnt), 64'd1, "R6 single reset pulse");
    check(active_o, packed_act(), "R6 soft reset defaults");
    rd_exp(12'h011, 2'd0, 1, 24'h0000A1, 1'b1, "R6 registers back to default");
    rd_exp(12'h000, 2'd0, 1, 24'h000000, 1'b1, "R6 config cleared");

    check(64'(exp_q.size()), 64'd0, "R2 all expected read bytes seen");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule